// File: doc/BRIEF.md
# Integrator Reset and Measure Sequencer

This block is the control state machine for a gated current-measurement front end. It watches a digitised supply-voltage code and does nothing while that code is too low. Once the supply is good it waits out a fixed calibration interval. After that it arms on the first rising edge of a combined reset request and then alternates forever between discharging the integrator and opening a measurement window. The analog integrator, the calibration itself and the output drivers live outside the block. The block only produces their control levels.

The combined reset request is the OR of up to `NUM_REQ` asynchronous timing inputs, each of which passes through its own two-flop synchroniser. Two timing modes exist. With `timer_mode` = 0 the discharge lasts for as long as the request is held. With `timer_mode` = 1 a request edge only starts the discharge, and a down-counter loaded from `reset_len` ends it. In level mode, a discharge that ends too early sets an active-low fault flag. When the direction flag reports reverse current, the measurement result is held at minimum.

States: `ST_LOCK` (supply low), `ST_CAL` (calibration wait), `ST_ARM` (waiting for the first request edge), `ST_RESET` (integrator discharge), `ST_MEASURE` (measurement window). Transitions: LOCK→CAL when the supply is good. CAL→ARM when the calibration count ends. ARM→RESET and MEASURE→RESET on a request rising edge. RESET→MEASURE when the discharge ends, which is the request falling in mode 0 or the timer expiring in mode 1. Any state→LOCK when the supply is no longer good.

Top module: `irm_seq`

## Requirements
- R1: While the block is locked out (supply not good), `integ_discharge`, `meas_enable` and `out_valid` are 0 and every reset request input is ignored.
- R2: The supply becomes good only when `supply_code` > `LOCK_THR + LOCK_HYST` (strictly greater). Once good, it becomes bad only when `supply_code` < `LOCK_THR`. Values in between keep the current condition.
- R3: After lockout ends, the block waits `CAL_CYCLES` clock cycles with all outputs at 0. Request edges during this wait are ignored and are not remembered.
- R4: After calibration, the first rising edge of the OR of the synchronised request inputs starts an integrator discharge (`integ_discharge` = 1). Any of the `NUM_REQ` inputs can cause it.
- R5: The cycle after a discharge ends, `meas_enable` = 1. It stays 1 until the next request rising edge starts a new discharge, and this pattern repeats without limit.
- R6: With `timer_mode` = 0, the discharge lasts exactly as many cycles as the request input was held high.
- R7: With `timer_mode` = 1, the discharge lasts max(`reset_len`, 1) cycles whatever the request level does after the triggering edge. Edges during the discharge are ignored.
- R8: In mode 0, a discharge shorter than `MIN_RST` cycles drives `fault_n` to 0 at its end. `fault_n` stays 0 through later short or mode-1 discharges until a mode-0 discharge of at least `MIN_RST` cycles ends, or until lockout. Both of those return it to 1.
- R9: When `reverse_flow` = 1, `out_valid` = 0 even inside a measurement window.
- R10: `integ_discharge` and `meas_enable` are never 1 together, and `out_valid` = 1 only while `meas_enable` = 1 and `reverse_flow` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_code | input | CODE_W | Digitised supply voltage |
| req_in | input | NUM_REQ | Asynchronous reset timing inputs, active high |
| timer_mode | input | 1 | 0: level sets discharge length, 1: timer sets it |
| reset_len | input | LEN_W | Discharge length in cycles for mode 1 |
| reverse_flow | input | 1 | 1 when current flows in the unmeasured direction |
| integ_discharge | output | 1 | Integrator discharge control |
| meas_enable | output | 1 | Measurement window open |
| out_valid | output | 1 | 1: report measurement, 0: hold output at minimum |
| fault_n | output | 1 | Active-low reset-timing fault |

## Verification
A wrong state in this block shows at the ports within a few cycles. A sequencer stuck in lock or calibration gives no discharge three cycles after a request edge. A premature arm gives a discharge from an edge seen during calibration. A bad length counter makes the count of discharge cycles differ from the held level or from `reset_len`. The bench therefore counts discharge cycles for every pulse width and timer value in a small configuration. It checks that a measurement window follows each discharge. It reads `fault_n` after every discharge, which exposes a wrong latch state at the first discharge that should have changed it.

// File: rtl/irm_pkg.sv
`timescale 1ns/1ps
package irm_pkg;

    typedef enum logic [2:0] {
        ST_LOCK    = 3'd0,
        ST_CAL     = 3'd1,
        ST_ARM     = 3'd2,
        ST_RESET   = 3'd3,
        ST_MEASURE = 3'd4
    } irm_state_e;

endpackage

// File: rtl/irm_req_sync.sv
`timescale 1ns/1ps
module irm_req_sync #(
    parameter int NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_in,
    output logic               req_any,
    output logic               req_rise
);

    logic [NUM_REQ-1:0] stage1_q;
    logic [NUM_REQ-1:0] stage2_q;
    logic               any_d_q;

    // one two-flop synchroniser per timing input
    genvar gi;
    generate
        for (gi = 0; gi < NUM_REQ; gi++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1_q[gi] <= 1'b0;
                    stage2_q[gi] <= 1'b0;
                end else begin
                    stage1_q[gi] <= req_in[gi];
                    stage2_q[gi] <= stage1_q[gi];
                end
            end
        end
    endgenerate

    assign req_any = |stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) any_d_q <= 1'b0;
        else        any_d_q <= req_any;
    end

    assign req_rise = req_any & ~any_d_q;

endmodule

// File: rtl/irm_supply_mon.sv
`timescale 1ns/1ps
module irm_supply_mon #(
    parameter int CODE_W    = 8,
    parameter int LOCK_THR  = 100,
    parameter int LOCK_HYST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] supply_code,
    output logic              supply_ok
);

    localparam int EXIT_LVL = LOCK_THR + LOCK_HYST;

    logic above_exit;
    logic below_thr;

    always_comb begin
        above_exit = int'(supply_code) > EXIT_LVL;
        below_thr  = int'(supply_code) < LOCK_THR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      supply_ok <= 1'b0;
        else if (!supply_ok && above_exit) supply_ok <= 1'b1;
        else if (supply_ok && below_thr)   supply_ok <= 1'b0;
    end

endmodule

// File: rtl/irm_rst_timer.sv
`timescale 1ns/1ps
module irm_rst_timer #(
    parameter int LEN_W   = 8,
    parameter int MIN_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic [LEN_W-1:0] len_in,
    output logic             expire,
    output logic             len_ok
);

    localparam int UP_W = $clog2(MIN_RST + 1) + 1;
    localparam logic [UP_W-1:0] UP_MAX = UP_W'(MIN_RST);

    logic [LEN_W-1:0] down_q;
    logic [UP_W-1:0]  up_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            down_q <= '0;
            up_q   <= '0;
        end else if (start) begin
            down_q <= len_in;
            up_q   <= UP_W'(1);
        end else if (active) begin
            if (down_q > LEN_W'(1)) down_q <= down_q - LEN_W'(1);
            if (up_q < UP_MAX)      up_q   <= up_q + UP_W'(1);
        end
    end

    // timer mode: current cycle is the last one of the discharge
    assign expire = down_q <= LEN_W'(1);
    // level mode: cycles spent so far reach the minimum
    assign len_ok = up_q >= UP_MAX;

endmodule

// File: rtl/irm_seq.sv
`timescale 1ns/1ps
module irm_seq
    import irm_pkg::*;
#(
    parameter int NUM_REQ    = 4,
    parameter int CODE_W     = 8,
    parameter int LOCK_THR   = 100,
    parameter int LOCK_HYST  = 8,
    parameter int CAL_CYCLES = 64,
    parameter int LEN_W      = 8,
    parameter int MIN_RST    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  supply_code,
    input  logic [NUM_REQ-1:0] req_in,
    input  logic               timer_mode,
    input  logic [LEN_W-1:0]   reset_len,
    input  logic               reverse_flow,
    output logic               integ_discharge,
    output logic               meas_enable,
    output logic               out_valid,
    output logic               fault_n
);

    localparam int CAL_W = $clog2(CAL_CYCLES + 1);
    localparam logic [CAL_W-1:0] CAL_LOAD = CAL_W'(CAL_CYCLES - 1);

    irm_state_e       state_q;
    irm_state_e       state_d;
    logic [CAL_W-1:0] cal_cnt_q;
    logic             mode_q;
    logic             fault_q;
    logic             supply_ok;
    logic             req_any;
    logic             req_rise;
    logic             rst_start;
    logic             rst_active;
    logic             tmr_expire;
    logic             len_ok;
    logic             rst_done;

    irm_supply_mon #(
        .CODE_W    (CODE_W),
        .LOCK_THR  (LOCK_THR),
        .LOCK_HYST (LOCK_HYST)
    ) u_supply (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_code (supply_code),
        .supply_ok   (supply_ok)
    );

    irm_req_sync #(
        .NUM_REQ (NUM_REQ)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (req_in),
        .req_any  (req_any),
        .req_rise (req_rise)
    );

    irm_rst_timer #(
        .LEN_W   (LEN_W),
        .MIN_RST (MIN_RST)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rst_start),
        .active (rst_active),
        .len_in (reset_len),
        .expire (tmr_expire),
        .len_ok (len_ok)
    );

    assign rst_active = (state_q == ST_RESET);
    assign rst_start  = (state_d == ST_RESET) && (state_q != ST_RESET);
    assign rst_done   = mode_q ? tmr_expire : !req_any;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCK:    if (supply_ok)         state_d = ST_CAL;
            ST_CAL:     if (cal_cnt_q == '0)   state_d = ST_ARM;
            ST_ARM:     if (req_rise)          state_d = ST_RESET;
            ST_RESET:   if (rst_done)          state_d = ST_MEASURE;
            ST_MEASURE: if (req_rise)          state_d = ST_RESET;
            default:                           state_d = ST_LOCK;
        endcase
        if (!supply_ok) state_d = ST_LOCK;
    end

    // state register and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_LOCK;
            cal_cnt_q <= CAL_LOAD;
            mode_q    <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_CAL)     cal_cnt_q <= CAL_LOAD;
            else if (cal_cnt_q != '0)  cal_cnt_q <= cal_cnt_q - CAL_W'(1);
            if (rst_start)             mode_q <= timer_mode;
            if (state_q == ST_LOCK)
                fault_q <= 1'b0;
            else if (rst_active && !mode_q && !req_any)
                fault_q <= !len_ok;
        end
    end

    // output decode
    always_comb begin
        integ_discharge = 1'b0;
        meas_enable     = 1'b0;
        out_valid       = 1'b0;
        unique case (state_q)
            ST_RESET:   integ_discharge = 1'b1;
            ST_MEASURE: begin
                meas_enable = 1'b1;
                out_valid   = !reverse_flow;
            end
            default: ;
        endcase
        fault_n = !fault_q;
    end

endmodule

// File: rtl/irm_seq_chk.sv
`timescale 1ns/1ps
module irm_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic integ_discharge,
    input logic meas_enable,
    input logic out_valid,
    input logic reverse_flow
);

    a_r1_lock_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!integ_discharge && !meas_enable && !out_valid));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(integ_discharge && meas_enable));

    a_r9_reverse_min: assert property (@(posedge clk) disable iff (!rst_n)
        reverse_flow |-> !out_valid);

    a_r5_measure_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(integ_discharge) && $past(supply_ok)) |-> meas_enable);

    a_r5_measure_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_enable) |-> $past(integ_discharge));

    a_r10_valid_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> meas_enable);

endmodule

bind irm_seq irm_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .supply_ok       (supply_ok),
    .integ_discharge (integ_discharge),
    .meas_enable     (meas_enable),
    .out_valid       (out_valid),
    .reverse_flow    (reverse_flow)
);

// File: tb/irm_seq_tb.sv
`timescale 1ns/1ps
module irm_seq_tb_top;

    localparam int NREQ = 4;
    localparam int CAL  = 6;
    localparam int MINR = 3;
    localparam int THR  = 100;
    localparam int HYS  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      supply_code = '0;
    logic [NREQ-1:0] req_in = '0;
    logic            timer_mode = 1'b0;
    logic [7:0]      reset_len = '0;
    logic            reverse_flow = 1'b0;
    logic            integ_discharge, meas_enable, out_valid, fault_n;

    int checks = 0;
    int fails  = 0;
    int dis_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irm_seq #(
        .NUM_REQ(NREQ), .CODE_W(8), .LOCK_THR(THR), .LOCK_HYST(HYS),
        .CAL_CYCLES(CAL), .LEN_W(8), .MIN_RST(MINR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .req_in(req_in),
        .timer_mode(timer_mode), .reset_len(reset_len), .reverse_flow(reverse_flow),
        .integ_discharge(integ_discharge), .meas_enable(meas_enable),
        .out_valid(out_valid), .fault_n(fault_n)
    );

    always @(posedge clk) begin
        #2;
        if (integ_discharge) dis_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int idx, input int h);
        dis_cnt = 0;
        req_in[idx] = 1'b1;
        repeat (h) @(negedge clk);
        req_in[idx] = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    task automatic supply(input int code);
        supply_code = 8'(code);
        repeat (CAL + 6) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!integ_discharge && !meas_enable && !out_valid, "R1 reset idle", int'(meas_enable), 0);
        chk(fault_n == 1'b1, "R8 reset fault_n", int'(fault_n), 1);

        // R2: below and at exit level stays locked
        supply(105);
        pulse(0, 4);
        chk(dis_cnt == 0, "R2 code 105 locked", dis_cnt, 0);
        supply(THR + HYS);
        pulse(1, 4);
        chk(dis_cnt == 0, "R2 code 108 locked", dis_cnt, 0);

        // R3: edge during calibration ignored
        supply_code = 8'(THR + HYS + 1);
        pulse(2, 2);
        chk(dis_cnt == 0, "R3 edge in cal ignored", dis_cnt, 0);
        chk(!meas_enable, "R3 no window before arm", int'(meas_enable), 0);

        // R4 R6 R8 R5: level mode sweep
        for (int h = 1; h <= 6; h++) begin
            pulse(h % NREQ, h);
            chk(dis_cnt == h, "R6 level length", dis_cnt, h);
            chk(fault_n == (h >= MINR), "R8 level fault", int'(fault_n), int'(h >= MINR));
            chk(meas_enable && out_valid, "R5 window after reset", int'(meas_enable), 1);
        end

        // R8 latch holds through mode 1
        pulse(3, 1);
        chk(fault_n == 1'b0, "R8 short sets fault", int'(fault_n), 0);

        // R7: timer mode sweep
        timer_mode = 1'b1;
        for (int l = 0; l <= 5; l++) begin
            reset_len = 8'(l);
            pulse(l % NREQ, 1);
            chk(dis_cnt == ((l < 1) ? 1 : l), "R7 timer length", dis_cnt, (l < 1) ? 1 : l);
            chk(fault_n == 1'b0, "R8 latch in timer mode", int'(fault_n), 0);
        end
        reset_len = 8'd3;
        pulse(0, 8);
        chk(dis_cnt == 3, "R7 level ignored", dis_cnt, 3);
        chk(meas_enable, "R5 window after timer", int'(meas_enable), 1);

        // R8: latch released only by long enough level reset
        timer_mode = 1'b0;
        pulse(1, 2);
        chk(fault_n == 1'b0, "R8 still short", int'(fault_n), 0);
        pulse(2, MINR);
        chk(fault_n == 1'b1, "R8 cleared at min", int'(fault_n), 1);

        // R9 R10
        reverse_flow = 1'b1;
        repeat (2) @(negedge clk);
        chk(meas_enable && !out_valid, "R9 reverse holds min", int'(out_valid), 0);
        reverse_flow = 1'b0;
        repeat (1) @(negedge clk);
        chk(out_valid, "R10 valid restored", int'(out_valid), 1);

        // R2: in-band code keeps running, below threshold locks
        pulse(0, 1);
        supply_code = 8'(THR);
        repeat (5) @(negedge clk);
        chk(meas_enable, "R2 code 100 keeps running", int'(meas_enable), 1);
        supply_code = 8'(THR - 1);
        repeat (4) @(negedge clk);
        chk(!meas_enable, "R1 lockout closes window", int'(meas_enable), 0);
        chk(fault_n == 1'b1, "R8 lockout clears fault", int'(fault_n), 1);
        pulse(3, 4);
        chk(dis_cnt == 0, "R1 request ignored in lock", dis_cnt, 0);

        // R3 R4: re-calibrate then arm
        supply(THR + HYS + 1);
        pulse(1, 4);
        chk(dis_cnt == 4, "R4 first edge after cal", dis_cnt, 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule